// File: doc/BRIEF.md
# Serial EEPROM two-wire slave controller

This block is the slave-side protocol engine of a two-wire serial memory holding 512 bytes. It runs on a fast system clock and synchronizes the bus lines SCL and SDA, then decodes START and STOP conditions from them. From the shifted-in bits it takes a select byte, a word address and data bytes, and it decides whether to acknowledge each one. It answers only through an active-low output enable for SDA: when the enable is high, the pad pulls the line low.

Write bytes go out as single-cycle strobes carrying a 9-bit address, and a commit strobe follows on STOP. A separate page-write block stages these bytes and raises a busy flag while its internal write cycle runs. Read data comes from an array read port that is addressed by the block's internal word address counter.

The select byte has a fixed device code in bits 7:4. Bits 3 and 2 are compared with two strap inputs. Bit 1 is the memory page bit, and bit 0 picks read or write. While the write cycle is busy, the select byte gets no acknowledge, so a master can poll until the write has finished.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. From any state, even part-way through a byte, a START begins reception of a new select byte and drops the partial byte. A repeated START after an acknowledged write select and a partial address byte leaves the word address counter unchanged.
- R2: Bus bits are sampled on SCL rising edges. sda_oe_o changes only while SCL is low.
- R3: The block acknowledges a select byte only if all of these hold: bits 7:4 are 1010, bit 3 equals a2_i, bit 2 equals a1_i, and wr_busy_i is low. To acknowledge, it holds sda_oe_o high for the ninth clock. A mismatching select gets no acknowledge, and the block then ignores the bus until the next START, acknowledging nothing.
- R4: After an acknowledged write select (bit 0 = 0), the next byte is the word address. The array address is {select bit 1, address byte}. The address byte and every data byte are acknowledged.
- R5: Each data byte produces a one-cycle wr_valid_o pulse with wr_addr_o and wr_data_o. After each data byte only the low 4 address bits advance, wrapping inside the 16-byte page (0x0FF is followed by 0x0F0).
- R6: A STOP after at least one data byte pulses wr_commit_o once. A write select or address that is ended by STOP or by a repeated START without data does not pulse it.
- R7: An acknowledged read select (bit 0 = 1, bit 1 ignored) returns the byte at the counter, MSB first. The counter holds the last accessed address plus one, so a repeated START read after a write select plus address is a random read.
- R8: A read continues with the next byte while the master acknowledges. The read counter rolls over from 511 to 0.
- R9: A master NACK on a read byte releases SDA and ends the transfer. The block ignores all further clocks until the next START.
- R10: While wr_busy_i is high, a correct select byte is not acknowledged. Once busy clears, the same select is acknowledged.
- R11: After reset sda_oe_o, wr_valid_o and wr_commit_o are low and the counter is 0. SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| a2_i | input | 1 | Strap compared with select bit 3 |
| a1_i | input | 1 | Strap compared with select bit 2 |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Array read data at rd_addr_o |
| sda_oe_o | output | 1 | SDA pull-low enable |
| wr_valid_o | output | 1 | Write byte strobe |
| wr_addr_o | output | 9 | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Start of the internal write cycle |
| rd_addr_o | output | 9 | Array read address (word address counter) |

## Verification
The select decode is exercised with a wrong device code and with a wrong strap. The second case is followed by an extra byte, which shows that a rejected block stays silent until the next START. A single byte write sits next to a three-byte page write that crosses the page end, so in-page wrap can be told apart from a plain increment. Random, current-address and sequential reads cross address 511 and confirm that reads roll over the whole array. A select sent during the busy window and again after it confirms polling. A repeated START cutting into an address byte shows that the counter is kept and select reception restarts.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int EEP_WORD_W = 8;
  localparam int EEP_ADDR_W = EEP_WORD_W + 1;
  localparam logic [3:0] EEP_DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      scl_q      <= scl_o;
      sda_q      <= sda_o;
    end
  end

  assign scl_o      = scl_pipe_q[SYNC_STAGES-1];
  assign sda_o      = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // conditions only count with SCL high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              page_wrap_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [PAGE_W-1:0] LO_ONE   = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] lo_next;

  assign lo_next = addr_q[PAGE_W-1:0] + LO_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (inc_i) begin
      if (page_wrap_i) addr_q <= {addr_q[ADDR_W-1:PAGE_W], lo_next};
      else             addr_q <= addr_q + ADDR_ONE;
    end
  end

  assign addr_o = addr_q;

  p_page_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && page_wrap_i && !load_i) |=>
      (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])));

  p_read_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !page_wrap_i && !load_i && (addr_o == '1)) |=> (addr_o == '0));
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
  import eep_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  a2_i,
  input  logic                  a1_i,
  input  logic                  wr_busy_i,
  input  logic [EEP_WORD_W-1:0] rd_data_i,
  output logic                  sda_oe_o,
  output logic                  wr_valid_o,
  output logic [EEP_ADDR_W-1:0] wr_addr_o,
  output logic [EEP_WORD_W-1:0] wr_data_o,
  output logic                  wr_commit_o,
  output logic [EEP_ADDR_W-1:0] rd_addr_o
);
  localparam int CNT_W = $clog2(EEP_WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(EEP_WORD_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(EEP_WORD_W);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  eep_state_e state_q, nxt_q;
  logic [CNT_W-1:0]      bit_cnt_q;
  logic [EEP_WORD_W-1:0] rx_q, tx_q, rx_byte;
  logic ack_q, page_bit_q, wr_any_q, oe_q;
  logic wr_valid_q, wr_commit_q;
  logic [EEP_ADDR_W-1:0] wr_addr_q, ctr_addr;
  logic [EEP_WORD_W-1:0] wr_data_q;
  logic byte_end, frame_end, sel_hit, rd_load, ctr_load, ctr_inc;

  assign rx_byte   = {rx_q[EEP_WORD_W-2:0], sda_s};
  assign byte_end  = scl_rise && (state_q != ST_IDLE) && (bit_cnt_q == LAST_BIT);
  assign frame_end = scl_rise && (state_q != ST_IDLE) && (bit_cnt_q == ACK_BIT);
  assign sel_hit   = (rx_byte[7:4] == EEP_DEV_CODE) && (rx_byte[3] == a2_i) &&
                     (rx_byte[2] == a1_i) && !wr_busy_i;

  // next byte fetched when a read select is acked or the master acks a read byte
  assign rd_load  = frame_end &&
                    ((state_q == ST_SEL && nxt_q == ST_RDATA && ack_q) ||
                     (state_q == ST_RDATA && !sda_s));
  assign ctr_load = byte_end && (state_q == ST_WADDR) && !bus_start && !bus_stop;
  assign ctr_inc  = ((byte_end && state_q == ST_WDATA) || rd_load) && !bus_start && !bus_stop;

  eep_addr_ctr #(.ADDR_W(EEP_ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i ({page_bit_q, rx_byte}),
    .inc_i      (ctr_inc),
    .page_wrap_i(state_q == ST_WDATA),
    .addr_o     (ctr_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ack_q      <= 1'b0;
      page_bit_q <= 1'b0;
      wr_any_q   <= 1'b0;
      oe_q       <= 1'b0;
    end else if (bus_start) begin
      state_q   <= ST_SEL;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      wr_any_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (bus_stop) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      wr_any_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q == ACK_BIT) begin
          bit_cnt_q <= '0;
          if (state_q == ST_RDATA) begin
            if (sda_s) state_q <= ST_IDLE;  // master NACK
            else       tx_q    <= rd_data_i;
          end else if (ack_q) begin
            state_q <= nxt_q;
            if (nxt_q == ST_RDATA) tx_q <= rd_data_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end else begin
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          rx_q      <= rx_byte;
          if (bit_cnt_q == LAST_BIT) begin
            unique case (state_q)
              ST_SEL: begin
                ack_q      <= sel_hit;
                page_bit_q <= rx_byte[1];
                nxt_q      <= rx_byte[0] ? ST_RDATA : ST_WADDR;
              end
              ST_WADDR: begin
                ack_q <= 1'b1;
                nxt_q <= ST_WDATA;
              end
              ST_WDATA: begin
                ack_q    <= 1'b1;
                nxt_q    <= ST_WDATA;
                wr_any_q <= 1'b1;
              end
              default: ack_q <= 1'b0;
            endcase
          end
        end
      end else if (scl_fall) begin
        if (bit_cnt_q == ACK_BIT) begin
          oe_q <= (state_q != ST_RDATA) && ack_q;
        end else if (state_q == ST_RDATA) begin
          oe_q <= ~tx_q[EEP_WORD_W-1];
          tx_q <= {tx_q[EEP_WORD_W-2:0], 1'b0};
        end else begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q  <= 1'b0;
      wr_commit_q <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_valid_q  <= byte_end && (state_q == ST_WDATA) && !bus_start && !bus_stop;
      wr_commit_q <= bus_stop && (state_q == ST_WDATA) && wr_any_q;
      if (byte_end && state_q == ST_WDATA) begin
        wr_addr_q <= ctr_addr;
        wr_data_q <= rx_byte;
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = wr_commit_q;
  assign rd_addr_o   = ctr_addr;

  // data strobe seen since the last START, used by the commit check
  logic seen_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_wr_q <= 1'b0;
    else if (bus_start || wr_commit_o) seen_wr_q <= 1'b0;
    else if (wr_valid_o)              seen_wr_q <= 1'b1;
  end

  p_oe_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  p_busy_nack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && state_q == ST_SEL && wr_busy_i && !bus_start && !bus_stop) |=> !ack_q);

  p_commit_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> seen_wr_q);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  p_strobe_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
endmodule

// File: tb/eeprom_2w_slave_bench.sv
module eeprom_2w_slave_bench;
  import eep_pkg::*;

  localparam int Q = 8;  // clocks per quarter bit

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic a2 = 1'b1, a1 = 1'b0;
  logic wr_busy = 1'b0;
  logic sda_oe, wr_valid, wr_commit;
  logic [8:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;

  logic [7:0] mem [512];

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  eeprom_2w_slave u_eeprom_2w_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .a2_i       (a2),
    .a1_i       (a1),
    .wr_busy_i  (wr_busy),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe),
    .wr_valid_o (wr_valid),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wr_commit_o(wr_commit),
    .rd_addr_o  (rd_addr)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0, busy_cnt = 0, r2_viol = 0;
  logic oe_prev = 1'b0;

  typedef struct packed {logic [8:0] a; logic [7:0] d;} wr_item_t;
  wr_item_t exp_wr[$];
  wr_item_t stage[$];
  logic [7:0] exp_rd[$];

  function automatic logic [7:0] mpat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: page-write model and write scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_wr.size() == 0) chk(0, "R5 unexpected strobe", int'(wr_addr), 0);
        else begin
          wr_item_t e;
          e = exp_wr.pop_front();
          chk(wr_addr == e.a && wr_data == e.d, "R5 write item",
              int'({wr_addr, wr_data}), int'({e.a, e.d}));
        end
        stage.push_back('{a: wr_addr, d: wr_data});
      end
      if (wr_commit) begin
        n_commit++;
        foreach (stage[k]) mem[stage[k].a] = stage[k].d;
        stage.delete();
        busy_cnt = 600;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
      end
      wr_busy = (busy_cnt > 0);
      if (sda_oe !== oe_prev && scl_m) r2_viol++;
      oe_prev = sda_oe;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    s = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic send_exp(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    send_byte(b, ack);
    chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
  endtask

  task automatic recv_chk(input logic master_ack, input string req);
    logic s;
    logic [7:0] b, e;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~master_ack, s);
    e = exp_rd.pop_front();
    chk(b == e, req, int'(b), int'(e));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  localparam logic [7:0] SEL_W0 = 8'b1010_1000;  // page 0, write
  localparam logic [7:0] SEL_W1 = 8'b1010_1010;  // page 1, write
  localparam logic [7:0] SEL_RD = 8'b1010_1001;  // read

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = mpat(i);
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R11 reset outputs",
        int'({sda_oe, wr_valid, wr_commit}), 0);
    chk(rd_addr == 9'd0, "R11 reset counter", int'(rd_addr), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R3 wrong device code
    bus_start();
    send_exp(8'b1001_1000, 1'b0, "R3 wrong code nack");
    bus_stop();
    // R3 wrong strap, then a following byte is ignored
    bus_start();
    send_exp(8'b1010_0000, 1'b0, "R3 wrong strap nack");
    send_exp(8'h00, 1'b0, "R3 ignored until START");
    bus_stop();

    // R4 byte write at 0x1F3
    bus_start();
    send_exp(SEL_W1, 1'b1, "R3 select ack");
    send_exp(8'hF3, 1'b1, "R4 address ack");
    exp_wr.push_back('{a: 9'h1F3, d: 8'h5A});
    send_exp(8'h5A, 1'b1, "R4 data ack");
    bus_stop();
    repeat (4) @(negedge clk);
    chk(n_commit == 1, "R6 commit after byte write", n_commit, 1);

    // R10 polling while busy
    bus_start();
    send_exp(SEL_W0, 1'b0, "R10 busy nack");
    bus_stop();
    repeat (800) @(negedge clk);
    bus_start();
    send_exp(SEL_W0, 1'b1, "R10 ack after busy");
    bus_stop();
    repeat (4) @(negedge clk);
    chk(n_commit == 1, "R6 no commit without data", n_commit, 1);

    // R7 random read of 0x1F3
    bus_start();
    send_exp(SEL_W1, 1'b1, "R7 dummy write select");
    send_exp(8'hF3, 1'b1, "R7 address ack");
    bus_start();
    send_exp(SEL_RD, 1'b1, "R7 read select ack");
    exp_rd.push_back(8'h5A);
    recv_chk(1'b0, "R7 random read data");
    bus_stop();
    chk(n_commit == 1, "R6 no commit on random read", n_commit, 1);

    // R7 current-address read -> 0x1F4
    bus_start();
    send_exp(SEL_RD, 1'b1, "R7 current select ack");
    exp_rd.push_back(mpat(9'h1F4));
    recv_chk(1'b0, "R7 current read data");
    bus_stop();

    // R5 page write crossing the page end
    bus_start();
    send_exp(SEL_W0, 1'b1, "R5 select ack");
    send_exp(8'hFE, 1'b1, "R5 address ack");
    exp_wr.push_back('{a: 9'h0FE, d: 8'h11});
    exp_wr.push_back('{a: 9'h0FF, d: 8'h22});
    exp_wr.push_back('{a: 9'h0F0, d: 8'h33});
    send_exp(8'h11, 1'b1, "R5 data0 ack");
    send_exp(8'h22, 1'b1, "R5 data1 ack");
    send_exp(8'h33, 1'b1, "R5 data2 ack");
    bus_stop();
    repeat (800) @(negedge clk);
    chk(n_commit == 2 && exp_wr.size() == 0, "R6 page commit", n_commit, 2);
    // counter after in-page wrap is 0x0F1
    bus_start();
    send_exp(SEL_RD, 1'b1, "R5 read select ack");
    exp_rd.push_back(mpat(9'h0F1));
    recv_chk(1'b0, "R5 counter after page wrap");
    bus_stop();

    // R8 sequential read across 511
    bus_start();
    send_exp(SEL_W1, 1'b1, "R8 select ack");
    send_exp(8'hFF, 1'b1, "R8 address ack");
    bus_start();
    send_exp(SEL_RD, 1'b1, "R8 read select ack");
    exp_rd.push_back(mpat(511));
    exp_rd.push_back(mpat(0));
    exp_rd.push_back(mpat(1));
    recv_chk(1'b1, "R8 byte 511");
    recv_chk(1'b1, "R8 rollover byte 0");
    recv_chk(1'b0, "R8 byte 1");
    // R9 after NACK no bit is driven
    begin
      int lows = 0;
      logic s;
      for (int i = 0; i < 9; i++) begin
        clk_bit(1'b1, s);
        if (!s) lows++;
      end
      chk(lows == 0, "R9 released after NACK", lows, 0);
    end
    bus_stop();
    bus_start();
    send_exp(SEL_RD, 1'b1, "R9 select after NACK");
    exp_rd.push_back(mpat(2));
    recv_chk(1'b0, "R9 next address read");
    bus_stop();

    // R1 repeated START cutting into an address byte
    bus_start();
    send_exp(SEL_W0, 1'b1, "R1 write select ack");
    begin
      logic s;
      clk_bit(1'b1, s);
      clk_bit(1'b1, s);
      clk_bit(1'b0, s);
      clk_bit(1'b0, s);
    end
    bus_start();
    send_exp(SEL_RD, 1'b1, "R1 select after restart");
    exp_rd.push_back(mpat(3));
    recv_chk(1'b0, "R1 counter kept");
    bus_stop();

    repeat (20) @(negedge clk);
    chk(r2_viol == 0, "R2 SDA enable changes with SCL low", r2_viol, 0);
    chk(n_commit == 2, "R6 total commits", n_commit, 2);
    summary();
    $finish;
  end
endmodule